// File: doc/BRIEF.md
# Framed Serial Command Link Master

This block runs one complete request/response exchange with a small peripheral controller over a four-wire link. The four wires are a bidirectional data line (split into `lnk_dout`, `lnk_oe` and `lnk_din`), an active-low frame-select line, a bit clock and a busy input. A start pulse begins the exchange. The master reads a length value and up to `MAX_LEN` payload bytes from a local buffer through a combinational address/data port. It frames them with a write address byte and closes them with a two's-complement checksum. It then polls the busy line until the peripheral reports ready. Finally it reads the reply frame back and drains it, showing each received byte on a strobed byte port.

All delays are counted in cycles of a single-cycle `tick` enable. A bit step lasts `BIT_TICKS` ticks and an inter-phase gap lasts `GAP_TICKS` ticks. A system clock of any rate can therefore produce link timing of tens of microseconds and milliseconds, and simulation can use short values. A one-cycle `done` marks the end of every exchange. `timeout` stays high from a failed poll until the next accepted start.

The master FSM has these states. IDLE goes to PRE on start. PRE: select, clock and data all high for one gap. WSEL: select low for one gap. WADDR: shift 0xE0. WGAP: one gap. WBODY: shift length, payload and checksum. POLL: sample busy at the end of each gap. RSEL: select low for one gap. RADDR: shift 0xE1. RGAP: one gap. RLEN: read the reply length. RBODY: read the remaining reply bytes. FINISH: one cycle, then back to IDLE. The transitions are as follows. POLL goes to RSEL on a low busy sample, or to FINISH after `POLL_TRIES` high samples. RBODY goes to FINISH after its last byte. Every other state moves on when its gap expires or its byte finishes. The bit engine has its own states: BIDLE, BLOW (clock low), BDATA (data driven, write only) and BHIGH (clock high, read sample at the end).

Top module: `cmdlink_master`

## Requirements
- R1: After reset and while idle, select is high, the link clock is high, the data line is driven (`lnk_oe`=1) at level 1, and `done` and `timeout` are low.
- R2: Each written bit has three steps of exactly `BIT_TICKS` ticks: clock low, then the data bit driven with clock still low, then clock high. The clock is therefore low for 2×`BIT_TICKS` ticks per written bit. A read bit has clock low for `BIT_TICKS` ticks, then clock high for `BIT_TICKS` ticks.
- R3: Bytes are shifted most-significant bit first in both directions. A written bit is valid at the clock's rising edge. A read bit is sampled at the end of the clock-high step and shifted into the least significant end.
- R4: The write frame is as follows. Select, clock and data are high for `GAP_TICKS` ticks. Select goes low for `GAP_TICKS` ticks. Then come byte 0xE0, a gap of `GAP_TICKS` ticks, the length byte, the payload bytes (buffer addresses 0 upward) and a checksum. The checksum is the 8-bit two's complement of the sum of the length and all payload bytes.
- R5: A requested length above `MAX_LEN` (14) is replaced by 14, both in the length byte sent and in the number of payload bytes sent.
- R6: After the write frame, select and data return high. The busy input is then sampled at the end of each of up to `POLL_TRIES` (8) consecutive gaps, and the first low sample starts the read phase. A peripheral that first shows low on the 8th sample is still served.
- R7: If all `POLL_TRIES` samples are high, `timeout` rises together with `done`, and select is not asserted again in that exchange.
- R8: The read phase is as follows. Select goes low for one gap. Then come byte 0xE1, one gap, a reply length byte L, and min(L,14)+1 further bytes. After that, select and data return high.
- R9: `lnk_oe` is low exactly while a read byte is being clocked in. At all other times the data line is driven.
- R10: Each byte read is shown on `rx_data` with a one-cycle `rx_valid`, including the reply length byte. `rx_last` is high only with the final byte of the reply (its checksum).
- R11: `done` is a one-cycle pulse at the end of every exchange. A start while an exchange is running is ignored. An accepted start clears `timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle timing enable for all delays |
| start | input | 1 | Begin an exchange (taken only when idle) |
| tx_len | input | 8 | Requested payload length |
| pay_addr | output | 4 | Payload buffer read address |
| pay_data | input | 8 | Payload byte at `pay_addr` (combinational read) |
| lnk_dout | output | 1 | Data line output level |
| lnk_oe | output | 1 | Data line output enable |
| lnk_din | input | 1 | Data line input level |
| lnk_sel | output | 1 | Frame select, active low |
| lnk_clk | output | 1 | Link bit clock |
| lnk_busy | input | 1 | Peripheral busy, low means ready |
| done | output | 1 | One-cycle end-of-exchange pulse |
| timeout | output | 1 | Peripheral never became ready |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_data` strobe |
| rx_last | output | 1 | Strobed byte is the reply checksum |

## Verification
A wrong bit-engine state shows up within one bit as a clock-low width other than 2×`BIT_TICKS` or `BIT_TICKS` ticks, or as the data line released during a write. A peripheral model decodes every byte on the link, so a wrong frame index or checksum accumulator shows up as a wrong captured byte at the end of the frame. A wrong poll or reply counter shows up as an early timeout, a missing 0xE1, or a reply of the wrong length or with `rx_last` in the wrong place, all of which are visible before `done`.

// File: rtl/cl_pkg.sv
package cl_pkg;

    localparam logic [7:0] ADDR_WRITE = 8'hE0;
    localparam logic [7:0] ADDR_READ  = 8'hE1;

    typedef enum logic [3:0] {
        M_IDLE, M_PRE, M_WSEL, M_WADDR, M_WGAP, M_WBODY, M_POLL,
        M_RSEL, M_RADDR, M_RGAP, M_RLEN, M_RBODY, M_FINISH
    } mst_state_t;

    typedef enum logic [1:0] {
        BIDLE, BLOW, BDATA, BHIGH
    } bit_state_t;

endpackage

// File: rtl/cl_tick_timer.sv
module cl_tick_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CW-1:0] cnt;

    assign expire = run && tick && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || expire)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1));

endmodule

// File: rtl/cl_byte_shifter.sv
module cl_byte_shifter
    import cl_pkg::*;
#(
    parameter int BIT_TICKS = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       go,
    input  logic       rd_mode,
    input  logic [7:0] tx_byte,
    input  logic       din,
    output logic       active,
    output logic       fin,
    output logic [7:0] rx_byte,
    output logic       line_clk,
    output logic       line_dout,
    output logic       line_oe
);
    bit_state_t st, st_nx;
    logic       rd_r;
    logic [7:0] tx_r;
    logic [7:0] rx_r;
    logic [2:0] bit_idx;
    logic       dout_r;
    logic       fin_r;
    logic       step_exp;

    cl_tick_timer #(.LIMIT(BIT_TICKS)) i_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st != BIDLE),
        .tick   (tick),
        .expire (step_exp)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            BIDLE: if (go) st_nx = BLOW;
            BLOW:  if (step_exp) st_nx = rd_r ? BHIGH : BDATA;
            BDATA: if (step_exp) st_nx = BHIGH;
            BHIGH: if (step_exp) st_nx = (bit_idx == 3'd7) ? BIDLE : BLOW;
            default: st_nx = BIDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= BIDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_r    <= 1'b0;
            tx_r    <= '0;
            rx_r    <= '0;
            bit_idx <= '0;
            dout_r  <= 1'b1;
            fin_r   <= 1'b0;
        end else begin
            fin_r <= 1'b0;
            if (st == BIDLE && go) begin
                rd_r    <= rd_mode;
                tx_r    <= tx_byte;
                bit_idx <= '0;
            end
            if (st == BLOW && step_exp && !rd_r)
                dout_r <= tx_r[3'd7 - bit_idx];
            if (st == BHIGH && step_exp) begin
                if (rd_r) rx_r <= {rx_r[6:0], din};
                bit_idx <= bit_idx + 3'd1;
                if (bit_idx == 3'd7) begin
                    fin_r  <= 1'b1;
                    dout_r <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        active    = (st != BIDLE);
        fin       = fin_r;
        rx_byte   = rx_r;
        line_clk  = !(st == BLOW || st == BDATA);
        line_dout = dout_r;
        line_oe   = !(active && rd_r);
    end

    // R2
    clk_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_clk) |-> $past(tick));

    // R3
    data_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_clk && $past(line_clk) && active) |-> $stable(line_dout));

endmodule

// File: rtl/cmdlink_master.sv
module cmdlink_master
    import cl_pkg::*;
#(
    parameter int BIT_TICKS  = 30,
    parameter int GAP_TICKS  = 1000,
    parameter int MAX_LEN    = 14,
    parameter int POLL_TRIES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] tx_len,
    output logic [3:0] pay_addr,
    input  logic [7:0] pay_data,
    output logic       lnk_dout,
    output logic       lnk_oe,
    input  logic       lnk_din,
    output logic       lnk_sel,
    output logic       lnk_clk,
    input  logic       lnk_busy,
    output logic       done,
    output logic       timeout,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_last
);
    localparam int IW = 4;
    localparam int PW = $clog2(POLL_TRIES + 1);
    localparam logic [7:0] MAXB = 8'(MAX_LEN);

    mst_state_t state, state_nx;
    logic [7:0]    len_r;
    logic [7:0]    fi;
    logic [7:0]    sum_r;
    logic [7:0]    rem;
    logic [PW-1:0] tries;
    logic          to_r;
    logic          inflight;

    logic          gap_run, gap_exp;
    logic          shift_st, sh_go, sh_rd, sh_active, sh_fin;
    logic [7:0]    sh_tx, sh_rx;
    logic          sh_clk, sh_dout, sh_oe;

    cl_tick_timer #(.LIMIT(GAP_TICKS)) i_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (gap_run),
        .tick   (tick),
        .expire (gap_exp)
    );

    cl_byte_shifter #(.BIT_TICKS(BIT_TICKS)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .go        (sh_go),
        .rd_mode   (sh_rd),
        .tx_byte   (sh_tx),
        .din       (lnk_din),
        .active    (sh_active),
        .fin       (sh_fin),
        .rx_byte   (sh_rx),
        .line_clk  (sh_clk),
        .line_dout (sh_dout),
        .line_oe   (sh_oe)
    );

    // next-state
    always_comb begin
        state_nx = state;
        unique case (state)
            M_IDLE:   if (start) state_nx = M_PRE;
            M_PRE:    if (gap_exp) state_nx = M_WSEL;
            M_WSEL:   if (gap_exp) state_nx = M_WADDR;
            M_WADDR:  if (sh_fin) state_nx = M_WGAP;
            M_WGAP:   if (gap_exp) state_nx = M_WBODY;
            M_WBODY:  if (sh_fin && fi == len_r + 8'd1) state_nx = M_POLL;
            M_POLL:   if (gap_exp) begin
                          if (!lnk_busy) state_nx = M_RSEL;
                          else if (tries == PW'(POLL_TRIES - 1)) state_nx = M_FINISH;
                      end
            M_RSEL:   if (gap_exp) state_nx = M_RADDR;
            M_RADDR:  if (sh_fin) state_nx = M_RGAP;
            M_RGAP:   if (gap_exp) state_nx = M_RLEN;
            M_RLEN:   if (sh_fin) state_nx = M_RBODY;
            M_RBODY:  if (sh_fin && rem == 8'd1) state_nx = M_FINISH;
            M_FINISH: state_nx = M_IDLE;
            default:  state_nx = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_r    <= '0;
            fi       <= '0;
            sum_r    <= '0;
            rem      <= '0;
            tries    <= '0;
            to_r     <= 1'b0;
            inflight <= 1'b0;
        end else begin
            if (sh_go)       inflight <= 1'b1;
            else if (sh_fin) inflight <= 1'b0;
            unique case (state)
                M_IDLE: if (start) begin
                    len_r <= (tx_len > MAXB) ? MAXB : tx_len;
                    fi    <= '0;
                    sum_r <= '0;
                    tries <= '0;
                    to_r  <= 1'b0;
                end
                M_WBODY: begin
                    if (sh_go && fi <= len_r) sum_r <= sum_r + sh_tx;
                    if (sh_fin) fi <= fi + 8'd1;
                end
                M_POLL: if (gap_exp && lnk_busy) begin
                    tries <= tries + 1'b1;
                    if (tries == PW'(POLL_TRIES - 1)) to_r <= 1'b1;
                end
                M_RLEN: if (sh_fin)
                    rem <= ((sh_rx > MAXB) ? MAXB : sh_rx) + 8'd1;
                M_RBODY: if (sh_fin) rem <= rem - 8'd1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        gap_run  = (state == M_PRE)  || (state == M_WSEL) || (state == M_WGAP) ||
                   (state == M_POLL) || (state == M_RSEL) || (state == M_RGAP);
        shift_st = (state == M_WADDR) || (state == M_WBODY) || (state == M_RADDR) ||
                   (state == M_RLEN)  || (state == M_RBODY);
        sh_go    = shift_st && !inflight;
        sh_rd    = (state == M_RLEN) || (state == M_RBODY);
        pay_addr = (fi == 8'd0) ? '0 : IW'(fi - 8'd1);
        unique case (state)
            M_WADDR: sh_tx = ADDR_WRITE;
            M_RADDR: sh_tx = ADDR_READ;
            M_WBODY: sh_tx = (fi == 8'd0)  ? len_r :
                             (fi <= len_r) ? pay_data : (8'd0 - sum_r);
            default: sh_tx = 8'd0;
        endcase
        lnk_sel  = (state == M_IDLE) || (state == M_PRE) ||
                   (state == M_POLL) || (state == M_FINISH);
        lnk_clk  = sh_clk;
        lnk_dout = sh_dout;
        lnk_oe   = sh_oe;
        done     = (state == M_FINISH);
        timeout  = to_r;
        rx_data  = sh_rx;
        rx_valid = sh_fin && sh_rd;
        rx_last  = sh_fin && (state == M_RBODY) && (rem == 8'd1);
    end

    // R4
    clk_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lnk_clk |-> !lnk_sel);

    // R9
    release_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lnk_oe |-> !lnk_sel);

    // R11
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> done);

    // R10
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_last |-> rx_valid);

    // R11
    busy_shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_IDLE) |-> !sh_active);

endmodule

// File: tb/test_cmdlink_master.sv
module test_cmdlink_master;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick = 0;
    logic       start = 0;
    logic [7:0] tx_len = 0;
    logic [3:0] pay_addr;
    logic [7:0] pay_data;
    logic       lnk_dout, lnk_oe, lnk_sel, lnk_clk;
    logic       lnk_din = 1;
    logic       lnk_busy = 0;
    logic       done, timeout, rx_valid, rx_last;
    logic [7:0] rx_data;

    always #10 clk = ~clk;

    cmdlink_master #(.BIT_TICKS(2), .GAP_TICKS(4)) i_cmdlink_master (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .tx_len(tx_len),
        .pay_addr(pay_addr), .pay_data(pay_data), .lnk_dout(lnk_dout),
        .lnk_oe(lnk_oe), .lnk_din(lnk_din), .lnk_sel(lnk_sel), .lnk_clk(lnk_clk),
        .lnk_busy(lnk_busy), .done(done), .timeout(timeout), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_last(rx_last));

    logic [7:0] pbuf [0:15];
    assign pay_data = pbuf[pay_addr];

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // tick every third cycle
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick = (tdiv == 0);
    end

    // peripheral model
    logic [7:0] cap [0:63];
    int ncap = 0, sel_falls = 0, oe_bad = 0, pbits = 0;
    logic [7:0] psh;
    bit pfirst = 0, preply = 0;
    logic [7:0] rep [0:31];
    int rbyte = 0, rbit = 0;

    always @(negedge lnk_sel) begin
        sel_falls++; pbits = 0; pfirst = 1; preply = 0;
    end
    always @(posedge lnk_clk) begin
        if (!preply) begin
            if (!lnk_oe) oe_bad++;
            psh = {psh[6:0], lnk_dout};
            pbits++;
            if (pbits == 8) begin
                pbits = 0;
                if (ncap < 64) cap[ncap] = psh;
                ncap++;
                if (pfirst && psh == 8'hE1) begin
                    preply = 1; rbyte = 0; rbit = 0;
                end
                pfirst = 0;
            end
        end else if (lnk_oe) oe_bad++;
    end
    always @(negedge lnk_clk) begin
        if (preply) begin
            lnk_din = rep[rbyte % 32][7 - rbit];
            rbit++;
            if (rbit == 8) begin rbit = 0; rbyte++; end
        end
    end
    always @(posedge lnk_sel) lnk_din = 1;

    // output monitors
    logic [7:0] rxc [0:31];
    bit rxl [0:31];
    int nrx = 0, ndone = 0, lowcnt = 0, nlow = 0;
    int lowlog [0:511];
    always @(negedge clk) begin
        if (rx_valid) begin
            if (nrx < 32) begin rxc[nrx] = rx_data; rxl[nrx] = rx_last; end
            nrx++;
        end
        if (done) ndone++;
        if (!lnk_clk) lowcnt++;
        else if (lowcnt != 0) begin
            if (nlow < 512) lowlog[nlow] = lowcnt;
            nlow++; lowcnt = 0;
        end
    end

    task automatic clear_mon();
        ncap = 0; sel_falls = 0; oe_bad = 0; nrx = 0; ndone = 0; nlow = 0;
    endtask

    task automatic kick(input int len);
        tx_len = len[7:0];
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
        if (!ok) chk(0, "R11 exchange watchdog", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    // full exchange with write and reply checks
    task automatic exchange(input int req, input int rlen, input string name);
        int lenc, sum, nexp;
        bit ok;
        lenc = (req > 14) ? 14 : req;
        for (int i = 0; i < 16; i++) pbuf[i] = 8'(i * 37 + req + 11);
        for (int i = 0; i < 32; i++) rep[i] = 8'(i * 29 + 5);
        rep[0] = 8'(rlen);
        clear_mon();
        kick(req);
        wait_done(ok);
        sum = lenc;
        for (int i = 0; i < lenc; i++) sum += pbuf[i];
        chk(ncap == lenc + 4, {"R4 byte count ", name}, ncap, lenc + 4);
        chk(cap[0] == 8'hE0, {"R4 write address ", name}, cap[0], 8'hE0);
        chk(cap[1] == 8'(lenc), {"R5 length byte ", name}, cap[1], lenc);
        for (int i = 0; i < lenc; i++)
            chk(cap[2 + i] == pbuf[i], {"R3 payload byte ", name}, cap[2 + i], pbuf[i]);
        chk(cap[lenc + 2] == 8'(-sum), {"R4 checksum ", name}, cap[lenc + 2], 8'(-sum));
        chk(cap[lenc + 3] == 8'hE1, {"R8 read address ", name}, cap[lenc + 3], 8'hE1);
        nexp = ((rlen > 14) ? 14 : rlen) + 2;
        chk(nrx == nexp, {"R8 reply byte count ", name}, nrx, nexp);
        for (int i = 0; i < nexp && i < 32; i++) begin
            chk(rxc[i] == rep[i], {"R10 reply byte ", name}, rxc[i], rep[i]);
            chk(rxl[i] == (i == nexp - 1), {"R10 last flag ", name}, rxl[i], i == nexp - 1);
        end
        chk(sel_falls == 2, {"R8 select windows ", name}, sel_falls, 2);
        chk(oe_bad == 0, {"R9 output enable ", name}, oe_bad, 0);
        chk(ndone == 1, {"R11 done pulses ", name}, ndone, 1);
        chk(timeout == 0, {"R6 no timeout ", name}, timeout, 0);
        chk(lnk_sel && lnk_dout && lnk_oe, {"R8 lines high after ", name},
            {lnk_sel, lnk_dout, lnk_oe}, 7);
        chk(lowlog[1] == 12, {"R2 write bit clock low ", name}, lowlog[1], 12);
        chk(lowlog[8 * (lenc + 4) + 1] == 6, {"R2 read bit clock low ", name},
            lowlog[8 * (lenc + 4) + 1], 6);
    endtask

    task automatic t_reset();
        chk(lnk_sel == 1, "R1 select idle", lnk_sel, 1);
        chk(lnk_clk == 1, "R1 clock idle", lnk_clk, 1);
        chk(lnk_oe == 1 && lnk_dout == 1, "R1 data idle", {lnk_oe, lnk_dout}, 3);
        chk(done == 0 && timeout == 0, "R1 flags idle", {done, timeout}, 0);
    endtask

    task automatic t_timeout();
        bit ok;
        for (int i = 0; i < 16; i++) pbuf[i] = 8'(i + 1);
        clear_mon();
        lnk_busy = 1;
        kick(2);
        wait_done(ok);
        chk(timeout == 1, "R7 timeout set", timeout, 1);
        chk(sel_falls == 1, "R7 no read select", sel_falls, 1);
        chk(ncap == 5, "R7 write only", ncap, 5);
        chk(nrx == 0, "R7 no reply bytes", nrx, 0);
        chk(ndone == 1, "R11 done on timeout", ndone, 1);
        lnk_busy = 0;
    endtask

    task automatic t_late_ready();
        bit ok;
        clear_mon();
        for (int i = 0; i < 32; i++) rep[i] = 8'(i + 100);
        rep[0] = 8'd1;
        lnk_busy = 1;
        kick(1);
        fork
            begin
                @(posedge lnk_sel);
                repeat (88) @(negedge clk);
                lnk_busy = 0;
            end
        join_none
        wait_done(ok);
        chk(timeout == 0, "R6 ready on final poll", timeout, 0);
        chk(nrx == 3, "R6 reply after final poll", nrx, 3);
        chk(timeout == 0, "R11 timeout cleared by start", timeout, 0);
    endtask

    task automatic t_start_ignored();
        bit ok;
        for (int i = 0; i < 16; i++) pbuf[i] = 8'(200 - i);
        for (int i = 0; i < 32; i++) rep[i] = 8'(i);
        rep[0] = 8'd0;
        clear_mon();
        kick(3);
        repeat (150) @(negedge clk);
        kick(9);
        wait_done(ok);
        repeat (400) @(negedge clk);
        chk(ndone == 1, "R11 start while busy ignored", ndone, 1);
        chk(sel_falls == 2, "R11 no extra frame", sel_falls, 2);
        chk(cap[1] == 8'd3, "R11 length kept", cap[1], 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        t_reset();
        exchange(5, 4, "basic");
        exchange(0, 0, "empty");
        exchange(14, 20, "full");
        exchange(30, 14, "clamped");
        t_timeout();
        t_late_ready();
        t_start_ignored();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "R11 global watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule